// File: doc/BRIEF.md
# Nibble-Bus BCD Real-Time Clock

This block keeps calendar time as decimal digits, one 4-bit nibble per digit, and shows it to a host through sixteen 4-bit registers in a single address space. Registers 0x0 to 0xC hold the time digits and the weekday. Registers 0xD, 0xE and 0xF are control registers. A one-cycle `sec_tick` strobe advances the time by one second, with decimal carry through to the year. Month length comes from a fixed table with February always 28 days. The time is loaded only through a parallel preset port. Host writes to the time registers are dropped.

The host port is synchronous. An address is sampled on each clock edge and its register contents appear on `bus_rdata` one cycle later. A write strobe stores a nibble into a control register. One control bit selects how the hour-tens register is shown: as the plain 24-hour tens digit, or as a 12-hour tens digit with a PM flag.

Every host write, including a dropped one, starts a countdown of frame ticks. When the countdown runs out, the block emits a one-cycle `persist_req`, so that the surrounding system can save the clock state to non-volatile storage.

Top module: `nibble_rtc`

## Requirements
- R1: After reset, control registers read D=0x1, E=0x0 and F=0x4. The time reads 00:00:00 on day 01, month 01, year 00, weekday 0. `persist_req` is low.
- R2: A write to address 0xD keeps only data bits 0 and 3. Bits 1 and 2 read back as zero.
- R3: Writes to addresses 0xE and 0xF store the full nibble, which reads back unchanged.
- R4: When F bit 2 is 1, address 0x5 returns the tens digit of the 24-hour hour. Address 0x4 returns the units digit of the 24-hour hour in both display modes.
- R5: When F bit 2 is 0, address 0x5 returns the tens digit of (hour mod 12) in bit 0 and sets bit 2 for hours 12 to 23. Bits 1 and 3 are zero.
- R6: Host writes to addresses 0x0 to 0xC leave the time unchanged.
- R7: While `preset_load` is high, the time is loaded from `preset_time`. Nibble i, at bits 4i+3 to 4i, is the value of register i. The hour tens are given in 24-hour form and the month is 1-based. If `sec_tick` is high in the same cycle, the preset wins.
- R8: Each `sec_tick` adds one second. Seconds and minutes carry in decimal from 59 to 00, and hours wrap from 23 to 00.
- R9: After the last day of a month, the day returns to 01 and the month advances. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 days and the others have 31. Month 12 wraps to 01 and increments the two-digit year, and year 99 wraps to 00.
- R10: The weekday (address 0xC) advances at every midnight and wraps from 6 to 0.
- R11: Any host write loads a countdown of 50 frame ticks. The cycle after the edge that consumes the 50th `frame_tick`, `persist_req` is high for exactly one cycle.
- R12: A write during the countdown restarts it from 50. A write that arrives in the same cycle as the final frame tick suppresses the pulse.
- R13: `bus_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe that adds one second |
| frame_tick | input | 1 | One-cycle strobe that clocks the persist countdown |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Registered read data for the previous address |
| preset_load | input | 1 | Load the time from preset_time |
| preset_time | input | 52 | Thirteen nibbles, one per time register 0x0 to 0xC |
| persist_req | output | 1 | One-cycle request to save the state |

## Verification
Two pairs of events can land in the same cycle. The first pair is a host write and the final frame tick of a running countdown: the restart must win and no pulse may appear, after which the full 50-tick delay must elapse before the next pulse. The second pair is a preset load and a second tick: the loaded time must read back unchanged. Both cases are driven deliberately with coincident strobes. The outcome is then judged at the ports, by watching `persist_req` on every tick and by reading back all time registers against an independent calendar model in the bench.

// File: rtl/nrtc_pkg.sv
package nrtc_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 4;
  localparam int TIME_NIBS = 13;
  localparam int TIME_W    = NIB_W * TIME_NIBS;
  localparam int MODE24_BIT = 2;

  localparam logic [NIB_W-1:0] CTL_D_RST  = 4'h1;
  localparam logic [NIB_W-1:0] CTL_E_RST  = 4'h0;
  localparam logic [NIB_W-1:0] CTL_F_RST  = 4'h4;
  localparam logic [NIB_W-1:0] CTL_D_MASK = 4'h9;

  localparam logic [ADDR_W-1:0] A_HR_T  = 4'h5;
  localparam logic [ADDR_W-1:0] A_LAST_TIME = 4'hC;
  localparam logic [ADDR_W-1:0] A_CTL_D = 4'hD;
  localparam logic [ADDR_W-1:0] A_CTL_E = 4'hE;
  localparam logic [ADDR_W-1:0] A_CTL_F = 4'hF;

  function automatic logic [6:0] bcd2bin(input logic [3:0] t, input logic [3:0] u);
    return ({3'b000, t} * 7'd10) + {3'b000, u};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m);
    case (m)
      7'd2:                         return 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:      return 7'd30;
      default:                      return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/nrtc_timekeeper.sv
module nrtc_timekeeper
  import nrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              preset_load,
  input  logic [TIME_W-1:0] preset_time,
  output logic [TIME_W-1:0] time_flat
);
  logic [NIB_W-1:0] sc_u, sc_t, mn_u, mn_t, hr_u, hr_t;
  logic [NIB_W-1:0] dy_u, dy_t, mo_u, mo_t, yr_u, yr_t, wd;

  logic c_sec, c_min, c_hr, c_day, c_mon, day_last;

  always_comb begin
    day_last = bcd2bin(dy_t, dy_u) >= month_len(bcd2bin(mo_t, mo_u));
    c_sec = (sc_u == 4'd9) && (sc_t == 4'd5);
    c_min = c_sec && (mn_u == 4'd9) && (mn_t == 4'd5);
    c_hr  = c_min && (hr_t == 4'd2) && (hr_u == 4'd3);
    c_day = c_hr && day_last;
    c_mon = c_day && (mo_t == 4'd1) && (mo_u == 4'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_u <= '0; sc_t <= '0; mn_u <= '0; mn_t <= '0; hr_u <= '0; hr_t <= '0;
      dy_u <= 4'd1; dy_t <= '0; mo_u <= 4'd1; mo_t <= '0;
      yr_u <= '0; yr_t <= '0; wd <= '0;
    end else if (preset_load) begin
      {wd, yr_t, yr_u, mo_t, mo_u, dy_t, dy_u, hr_t, hr_u, mn_t, mn_u, sc_t, sc_u} <= preset_time;
    end else if (sec_tick) begin
      if (sc_u == 4'd9) begin
        sc_u <= '0;
        sc_t <= (sc_t == 4'd5) ? 4'd0 : sc_t + 4'd1;
      end else begin
        sc_u <= sc_u + 4'd1;
      end
      if (c_sec) begin
        if (mn_u == 4'd9) begin
          mn_u <= '0;
          mn_t <= (mn_t == 4'd5) ? 4'd0 : mn_t + 4'd1;
        end else begin
          mn_u <= mn_u + 4'd1;
        end
      end
      if (c_min) begin
        if (c_hr) begin
          hr_u <= '0; hr_t <= '0;
        end else if (hr_u == 4'd9) begin
          hr_u <= '0; hr_t <= hr_t + 4'd1;
        end else begin
          hr_u <= hr_u + 4'd1;
        end
      end
      if (c_hr) begin
        wd <= (wd >= 4'd6) ? 4'd0 : wd + 4'd1;
        if (c_day) begin
          dy_u <= 4'd1; dy_t <= '0;
        end else if (dy_u == 4'd9) begin
          dy_u <= '0; dy_t <= dy_t + 4'd1;
        end else begin
          dy_u <= dy_u + 4'd1;
        end
      end
      if (c_day) begin
        if (c_mon) begin
          mo_u <= 4'd1; mo_t <= '0;
        end else if (mo_u == 4'd9) begin
          mo_u <= '0; mo_t <= mo_t + 4'd1;
        end else begin
          mo_u <= mo_u + 4'd1;
        end
      end
      if (c_mon) begin
        if (yr_u == 4'd9) begin
          yr_u <= '0;
          yr_t <= (yr_t == 4'd9) ? 4'd0 : yr_t + 4'd1;
        end else begin
          yr_u <= yr_u + 4'd1;
        end
      end
    end
  end

  assign time_flat = {wd, yr_t, yr_u, mo_t, mo_u, dy_t, dy_u, hr_t, hr_u, mn_t, mn_u, sc_t, sc_u};
endmodule

// File: rtl/nrtc_ctrl_regs.sv
module nrtc_ctrl_regs
  import nrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wdata,
  output logic [NIB_W-1:0]  ctl_d,
  output logic [NIB_W-1:0]  ctl_e,
  output logic [NIB_W-1:0]  ctl_f
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_d <= CTL_D_RST;
      ctl_e <= CTL_E_RST;
      ctl_f <= CTL_F_RST;
    end else if (wr) begin
      case (addr)
        A_CTL_D: ctl_d <= wdata & CTL_D_MASK;
        A_CTL_E: ctl_e <= wdata;
        A_CTL_F: ctl_f <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nrtc_read_mux.sv
module nrtc_read_mux
  import nrtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [TIME_W-1:0] time_flat,
  input  logic [NIB_W-1:0]  ctl_d,
  input  logic [NIB_W-1:0]  ctl_e,
  input  logic [NIB_W-1:0]  ctl_f,
  output logic [NIB_W-1:0]  value
);
  logic [NIB_W-1:0] nib [TIME_NIBS];
  logic [6:0] hr_bin, hr12;
  logic [NIB_W-1:0] hr_tens_view;

  for (genvar i = 0; i < TIME_NIBS; i++) begin : g_nib
    assign nib[i] = time_flat[i*NIB_W +: NIB_W];
  end

  always_comb begin
    hr_bin = bcd2bin(nib[5], nib[4]);
    hr12   = (hr_bin >= 7'd12) ? hr_bin - 7'd12 : hr_bin;
    if (ctl_f[MODE24_BIT])
      hr_tens_view = nib[5];
    else
      hr_tens_view = {1'b0, hr_bin >= 7'd12, 1'b0, hr12 >= 7'd10};
  end

  always_comb begin
    value = '0;
    if (addr == A_HR_T)            value = hr_tens_view;
    else if (addr == A_CTL_D)      value = ctl_d;
    else if (addr == A_CTL_E)      value = ctl_e;
    else if (addr == A_CTL_F)      value = ctl_f;
    else begin
      for (int k = 0; k < TIME_NIBS; k++)
        if (addr == ADDR_W'(k)) value = nib[k];
    end
  end
endmodule

// File: rtl/nrtc_persist_timer.sv
module nrtc_persist_timer #(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic frame_tick,
  output logic pulse
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (arm) begin
        cnt <= LOAD;
      end else if (frame_tick && cnt != '0) begin
        cnt   <= cnt - ONE;
        pulse <= (cnt == ONE);
      end
    end
  end
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import nrtc_pkg::*;
#(
  parameter int PERSIST_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              frame_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              preset_load,
  input  logic [TIME_W-1:0] preset_time,
  output logic              persist_req
);
  logic [TIME_W-1:0] time_flat;
  logic [NIB_W-1:0]  ctl_d, ctl_e, ctl_f, rd_val;

  nrtc_timekeeper u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .preset_load(preset_load), .preset_time(preset_time), .time_flat(time_flat)
  );

  nrtc_ctrl_regs u_ctl (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctl_d(ctl_d), .ctl_e(ctl_e), .ctl_f(ctl_f)
  );

  nrtc_read_mux u_mux (
    .addr(bus_addr), .time_flat(time_flat),
    .ctl_d(ctl_d), .ctl_e(ctl_e), .ctl_f(ctl_f), .value(rd_val)
  );

  nrtc_persist_timer #(.TICKS(PERSIST_TICKS)) u_persist (
    .clk(clk), .rst(rst), .arm(bus_wr), .frame_tick(frame_tick), .pulse(persist_req)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_val;
  end
endmodule

// File: rtl/nrtc_chk.sv
module nrtc_chk
  import nrtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              bus_wr,
  input logic              preset_load,
  input logic [TIME_W-1:0] preset_time,
  input logic [TIME_W-1:0] time_flat,
  input logic [NIB_W-1:0]  ctl_d,
  input logic              persist_req
);
  // R2
  d_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_d[2:1] == 2'b00);

  // R6
  time_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !preset_load && !sec_tick) |=> $stable(time_flat));

  // R7
  preset_take_chk: assert property (@(posedge clk) disable iff (rst)
    preset_load |=> (time_flat == $past(preset_time)));

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    persist_req |=> !persist_req);

  // R12
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !persist_req);
endmodule

bind nibble_rtc nrtc_chk u_nrtc_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_wr(bus_wr),
  .preset_load(preset_load), .preset_time(preset_time),
  .time_flat(time_flat), .ctl_d(ctl_d), .persist_req(persist_req)
);

// File: tb/tb_nibble_rtc.sv
module tb_nibble_rtc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0, frame_tick = 1'b0, bus_wr = 1'b0, preset_load = 1'b0;
  logic [3:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic [51:0] preset_time = '0;
  logic persist_req;

  int n_chk = 0, n_bad = 0;
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd;
  logic [3:0] m_d, m_e, m_f;

  always #4 clk = ~clk;

  nibble_rtc dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .frame_tick(frame_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .preset_load(preset_load), .preset_time(preset_time), .persist_req(persist_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mdays(input int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_reg(input int a);
    case (a)
      0: return m_sec % 10;   1: return m_sec / 10;
      2: return m_min % 10;   3: return m_min / 10;
      4: return m_hr % 10;
      5: return m_f[2] ? m_hr / 10 : (((m_hr % 12) >= 10) ? 1 : 0) | ((m_hr >= 12) ? 4 : 0);
      6: return m_day % 10;   7: return m_day / 10;
      8: return m_mon % 10;   9: return m_mon / 10;
      10: return m_yr % 10;   11: return m_yr / 10;
      12: return m_wd;
      13: return m_d;  14: return m_e;
      default: return m_f;
    endcase
  endfunction

  function automatic void model_tick();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
          if (m_day > mdays(m_mon)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endfunction

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 4'(d);
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 13) m_d = 4'(d) & 4'h9;
    if (a == 14) m_e = 4'(d);
    if (a == 15) m_f = 4'(d);
  endtask

  task automatic do_read(input int a, output int v);
    @(negedge clk);
    bus_addr = 4'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic read_all(input string tag);
    int v;
    for (int a = 0; a < 16; a++) begin
      do_read(a, v);
      check($sformatf("%s reg%0d", tag, a), v, exp_reg(a));
    end
  endtask

  task automatic tick_sec(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      model_tick();
    end
  endtask

  task automatic do_preset(input int s, input int mi, input int h, input int d,
                           input int mo, input int y, input int w, input bit with_tick);
    m_sec = s; m_min = mi; m_hr = h; m_day = d; m_mon = mo; m_yr = y; m_wd = w;
    @(negedge clk);
    preset_time = {4'(w), 4'(y/10), 4'(y%10), 4'(mo/10), 4'(mo%10), 4'(d/10), 4'(d%10),
                   4'(h/10), 4'(h%10), 4'(mi/10), 4'(mi%10), 4'(s/10), 4'(s%10)};
    preset_load = 1'b1; sec_tick = with_tick;
    @(negedge clk);
    preset_load = 1'b0; sec_tick = 1'b0;
  endtask

  // n frame ticks; returns count of early pulses and the state after the last tick
  task automatic frame_ticks(input int n, output int early, output int last);
    early = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
      if (i < n - 1) early += int'(persist_req);
      else last = int'(persist_req);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, early, last;
    void'($urandom(32'h5EED1234));
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 0;
    m_d = 4'h1; m_e = 4'h0; m_f = 4'h4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 persist_req after reset", int'(persist_req), 0);
    read_all("R1 R13 reset");

    // R2 and R3: control writes
    do_write(13, 15); do_read(13, v); check("R2 D masked 0xF", v, 9);
    do_write(13, 6);  do_read(13, v); check("R2 D masked 0x6", v, 0);
    do_write(14, 10); do_read(14, v); check("R3 E full", v, 10);
    do_write(15, 11); do_read(15, v); check("R3 F full", v, 11);

    // R4 R5: hour display modes
    do_preset(0, 0, 23, 5, 3, 21, 2, 1'b0);
    do_write(15, 4); read_all("R4 24h 23h");
    do_write(15, 0); read_all("R5 12h 23h");
    do_preset(0, 0, 12, 5, 3, 21, 2, 1'b0); read_all("R5 12h noon");
    do_preset(0, 0, 10, 5, 3, 21, 2, 1'b0); read_all("R5 12h 10am");
    do_preset(0, 0, 0, 5, 3, 21, 2, 1'b0);  read_all("R5 12h midnight");
    do_write(15, 4);

    // R6: ignored time writes
    for (int i = 0; i < 13; i++) begin
      do_write(i, (i + 7) % 16);
      do_read(i, v);
      check($sformatf("R6 write ignored reg%0d", i), v, exp_reg(i));
    end

    // R7: preset and tick in the same cycle
    do_preset(58, 59, 23, 28, 2, 99, 6, 1'b1);
    read_all("R7 preset beats tick");

    // R8 R9 R10: directed rollovers
    tick_sec(2); read_all("R8 R9 R10 feb28 rollover");
    do_preset(59, 59, 23, 31, 12, 99, 6, 1'b0); tick_sec(1); read_all("R9 R10 year wrap");
    do_preset(59, 59, 23, 30, 4, 5, 3, 1'b0); tick_sec(1); read_all("R9 april end");
    do_preset(59, 59, 23, 30, 1, 5, 3, 1'b0); tick_sec(1); read_all("R9 jan 30");
    do_preset(50, 59, 9, 1, 1, 9, 0, 1'b0); tick_sec(12); read_all("R8 hour digit carry");

    // constrained random
    for (int it = 0; it < 30; it++) begin
      int mo;
      mo = 1 + int'($urandom % 12);
      do_preset(int'($urandom % 60), int'($urandom % 60), int'($urandom % 24),
                1 + int'($urandom % mdays(mo)), mo, int'($urandom % 100),
                int'($urandom % 7), 1'b0);
      do_write(15, int'($urandom % 16));
      tick_sec(int'($urandom % 70));
      read_all($sformatf("R4 R5 R8 random%0d", it));
    end

    // R11: plain countdown
    do_write(14, 3);
    frame_ticks(50, early, last);
    check("R11 no early pulse", early, 0);
    check("R11 pulse after 50 ticks", last, 1);
    @(negedge clk); check("R11 pulse one cycle", int'(persist_req), 0);

    // R12: restart mid-count
    do_write(3, 1);
    frame_ticks(30, early, last);
    check("R12 no pulse before restart", early + last, 0);
    do_write(14, 5);
    frame_ticks(50, early, last);
    check("R12 restart no early", early, 0);
    check("R12 restart pulse at 50", last, 1);

    // R12: write on the final tick
    do_write(14, 6);
    frame_ticks(49, early, last);
    check("R12 49 ticks quiet", early + last, 0);
    @(negedge clk); frame_tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd14; bus_wdata = 4'd7;
    @(negedge clk); frame_tick = 1'b0; bus_wr = 1'b0; m_e = 4'd7;
    check("R12 coincident write suppresses", int'(persist_req), 0);
    frame_ticks(50, early, last);
    check("R12 after coincidence no early", early, 0);
    check("R12 after coincidence pulse", last, 1);
    do_read(14, v); check("R3 E after coincident write", v, 7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule